// File: doc/BRIEF.md
# Data bus inversion flag generator

This block takes an 8-bit word with a valid strobe and registers it. From the registered word it produces an inversion flag and the word to put on the bus. The flag goes high when the word has four or more ones. In that case the bus carries the bitwise inverse of the word, so at most four lines are driven high. Otherwise the word passes through unchanged.

The ones count is kept in a 3-bit sum. That sum wraps to zero when all eight bits are set. The block does not widen the sum. It ORs in one 4-input AND gate that reads four fixed bits straight from the word register. This product is high for an all-ones word, so the wrap is covered. It can only be high otherwise when those four bits are set, and such a word needs the flag anyway.

A parameter selects how the final gate is built: an AND-OR form, or a form made only of 4-input NAND gates. Both forms give the same function.

Top module: `dbi_flag_gen`

## Requirements
- R1: While reset is asserted, and until the first valid word has been accepted, out_valid, out_flag and out_data are all zero.
- R2: For every 8-bit word accepted, out_flag is 1 exactly when the word has four or more bits set.
- R3: The word 8'hFF produces out_flag = 1 and out_data = 8'h00, even though the 3-bit count wraps to zero.
- R4: Every word with exactly four ones produces out_flag = 1. This includes 8'h0F, whose set bits are exactly the four correction taps (bits 3, 2, 1, 0 by default).
- R5: Every word with three or fewer ones produces out_flag = 0 and is sent unchanged.
- R6: When out_flag is 1, out_data is the bitwise inverse of the accepted word. When out_flag is 0, out_data equals the accepted word.
- R7: A word presented with in_valid high at a rising clock edge appears on the outputs right after that edge. out_valid is in_valid delayed by one cycle.
- R8: When in_valid is low at a clock edge, in_data is ignored, and out_data and out_flag keep their previous values.
- R9: The NAND-only build (NAND_ONLY = 1) produces, for every word, the same out_flag and out_data as the AND-OR build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word strobe |
| in_data | input | 8 | Input word |
| out_valid | output | 1 | Output word strobe, one cycle after in_valid |
| out_data | output | 8 | Word driven on the bus, inverted when out_flag is 1 |
| out_flag | output | 1 | Inversion flag |

## Verification
Two terms feed the flag: the compare on the narrow sum and the correction product. In most words only one of them decides the flag. For 8'h0F both fire in the same cycle, because the sum is exactly four and all four tapped bits are set. For 8'hFF only the correction fires, because the sum has wrapped to zero. Both words are sent directly. They are also reached by the full sweep of all 256 words and by the random words with idle gaps. Each result is judged against a reference that counts the ones at full width, on both the AND-OR build and the NAND-only build.

// File: rtl/dbi_flag_gen.sv
module dbi_flag_gen #(
  parameter int W         = 8,
  parameter int TAP_A     = 0,
  parameter int TAP_B     = 1,
  parameter int TAP_C     = 2,
  parameter int TAP_D     = 3,
  parameter bit NAND_ONLY = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [7:0]   in_data,
  output logic         out_valid,
  output logic [7:0]   out_data,
  output logic         out_flag
);
  localparam int SW = 3;

  logic [W-1:0]  word_q;
  logic          vld_q;
  logic [SW-1:0] narrow_sum;
  logic          over_half;
  logic          tap_all;
  logic          flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) word_q <= in_data;
    end
  end

  // Deliberately narrow: the sum wraps to zero on an all-ones word
  always_comb begin
    narrow_sum = '0;
    for (int i = 0; i < W; i++) narrow_sum = narrow_sum + SW'(word_q[i]);
  end

  assign over_half = (narrow_sum > SW'(3));

  generate
    if (NAND_ONLY) begin : g_nand
      logic n_taps, n_cmp;
      assign n_taps = ~(word_q[TAP_A] & word_q[TAP_B] & word_q[TAP_C] & word_q[TAP_D]);
      assign n_cmp  = ~(over_half & over_half & over_half & over_half);
      assign flag   = ~(n_taps & n_cmp & 1'b1 & 1'b1);
      assign tap_all = ~n_taps;
    end else begin : g_andor
      assign tap_all = word_q[TAP_A] & word_q[TAP_B] & word_q[TAP_C] & word_q[TAP_D];
      assign flag    = over_half | tap_all;
    end
  endgenerate

  assign out_valid = vld_q;
  assign out_flag  = flag;
  assign out_data  = word_q ^ {W{flag}};
endmodule

module dbi_flag_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] in_data,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_flag
);
  always_comb if (!rst_n) assert_reset_idle_R1: assert (!out_valid && !out_flag && out_data == 8'h00);

  assert_valid_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  assert_inverse_or_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_data == (out_flag ? ~$past(in_data) : $past(in_data)));

  assert_all_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data == 8'hFF) |=> (out_flag && out_data == 8'h00));

  assert_bus_weight_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flag ? ($countones(out_data) <= 4) : ($countones(out_data) <= 3)));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(out_flag)));
endmodule

bind dbi_flag_gen dbi_flag_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .out_valid(out_valid), .out_data(out_data), .out_flag(out_flag)
);

// File: tb/dbi_flag_gen_bench.sv
module dbi_flag_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       ao_valid, nd_valid, ao_flag, nd_flag;
  logic [7:0] ao_data, nd_data;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dbi_flag_gen u_dbi_flag_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(ao_valid), .out_data(ao_data), .out_flag(ao_flag));

  dbi_flag_gen #(.NAND_ONLY(1'b1)) u_dbi_flag_gen_nand (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(nd_valid), .out_data(nd_data), .out_flag(nd_flag));

  function automatic bit ref_flag(input logic [7:0] d);
    int n = 0;
    for (int i = 0; i < 8; i++) n += int'(d[i]);
    return n >= 4;
  endfunction

  function automatic logic [7:0] ref_bus(input logic [7:0] d);
    return ref_flag(d) ? ~d : d;
  endfunction

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    chk(req, {ao_flag, ao_data}, {ref_flag(d), ref_bus(d)});
    chk("R9", {nd_flag, nd_data}, {ao_flag, ao_data});
    chk("R7", {8'h00, ao_valid}, 9'h001);
  endtask

  task automatic idle(input logic [7:0] junk, input logic [7:0] last);
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = junk;
    @(negedge clk);
    chk("R8", {ao_flag, ao_data}, {ref_flag(last), ref_bus(last)});
    chk("R7", {8'h00, ao_valid}, 9'h000);
  endtask

  initial begin
    logic [7:0] w;
    logic [7:0] last;
    void'($urandom(32'h1D5E_0B17));
    repeat (3) @(negedge clk);
    chk("R1", {ao_flag, ao_data}, 9'h000);
    chk("R1", {8'h00, ao_valid}, 9'h000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {ao_flag, ao_data}, 9'h000);

    send(8'hFF, "R3");
    send(8'h0F, "R4");
    send(8'hF0, "R4");
    send(8'h07, "R5");
    send(8'h00, "R5");
    send(8'h0E, "R5");
    idle(8'hFF, 8'h0E);

    for (int v = 0; v < 256; v++) send(8'(v), "R2");
    last = 8'hFF;

    for (int k = 0; k < 300; k++) begin
      w = 8'($urandom);
      if ($urandom % 4 == 0) idle(w, last);
      else begin
        send(w, "R6");
        last = w;
      end
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=running exp=done");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule